// File: doc/BRIEF.md
# Byte-wide Asynchronous Static RAM Controller

This block connects a simple internal request/acknowledge port to an external asynchronous static RAM that holds 131,072 bytes. One request moves one byte. The block drives a 17-bit address and two chip selects of opposite polarity: `ce_n` is active low and `ce2` is active high. It also drives an active-low write strobe and an active-low output enable. The bidirectional data pins are split into `dq_out`, `dq_in` and a driver enable `dq_oe`.

The controller builds every bus phase from whole clock cycles. It derives the cycle counts from nanosecond limits given as parameters. Each count is the ceiling of the limit divided by the clock period, and it is never less than one.

- A read holds the device selected with the output enable low for the access time, then captures the byte.
- A write first spends one cycle selected with both strobes high, which is the output-disable condition. It then lowers the write strobe and drives the data for the strobe time.
- After a read, the device is deselected for a turnaround interval so that it releases the bus before the next transfer.
- When no request is pending, the controller keeps the device in standby.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and after reset, and whenever no transfer is in progress, the controller keeps the device in standby: `ce_n`=1, `ce2`=0, `we_n`=1, `oe_n`=1 and `dq_oe`=0.
- R2: A read request (`req`=1, `req_we`=0) places its address on `sram_addr` and holds `ce_n`=0, `ce2`=1, `we_n`=1 and `oe_n`=0 for RD cycles, where RD = ceil(max(T_RC, T_AA, T_ACE, T_OE) / CLK_NS). At the end of the last of those cycles the byte on `dq_in` is captured into `rdata`.
- R3: A write request (`req_we`=1) first gives exactly one selected cycle with `we_n`=1 and `oe_n`=1. It then holds `we_n`=0 for WP cycles, where WP = ceil(max(T_WP, T_AW, T_CW, T_DW) / CLK_NS), and the written byte is `req_wdata`.
- R4: `dq_oe` is 1 exactly in the cycles in which `we_n` is 0, so the controller never drives data while the output enable is low.
- R5: After a read, the device stays deselected (`ce_n`=1) and `dq_oe` stays 0 for at least TA cycles, where TA = ceil(max(T_OHZ, T_CHZ) / CLK_NS), before the next transfer begins.
- R6: Every accepted request produces exactly one `ack` pulse, which lasts one cycle. The pulse arrives RD cycles after acceptance for a read and 1+WP cycles for a write, measured from the first cycle in which `ce_n` is low. For a read, `rdata` is valid in the same cycle as `ack`.
- R7: A request is sampled only while the controller is idle. A request presented during a transfer has no effect, and `sram_addr` stays constant while the device is selected.
- R8: Every phase count is at least one cycle even when a limit is shorter than a clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transfer request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read, valid with `ack` |
| sram_addr | output | 17 | Memory address bus |
| dq_out | output | 8 | Data driven toward the memory |
| dq_in | input | 8 | Data received from the memory |
| dq_oe | output | 1 | Enable for the data driver |
| ce_n | output | 1 | Chip select, active low |
| ce2 | output | 1 | Chip select, active high |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |

## Verification
The assertions check on every cycle the properties that hold locally in time:

- `ack` is a single-cycle pulse;
- the data driver never coincides with a low output enable;
- the driver turns on only after an output-disable cycle;
- the bus goes quiet after a read ends;
- the address holds steady while the device is selected.

Several behaviours need the bench's scenarios instead. These are the exact phase lengths, the point at which read data has become valid at the memory, the bytes actually stored and returned, the length of the turnaround gap, and the fact that a request raised during a transfer leaves memory untouched. The bench shows them with a memory model that returns wrong data until the access time has elapsed.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_WSET,
        PH_WSTB
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic drive;
    } pins_t;

    function automatic int unsigned cycles_for(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(int unsigned v);
        int unsigned w;
        w = 1;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

    function automatic pins_t pins_for(phase_e p);
        pins_t s;
        s = '{ce_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (p)
            PH_READ: s = '{ce_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            PH_WSET: s = '{ce_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            PH_WSTB: s = '{ce_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R8: a loaded count of N finishes after N further cycles
    assert_count_down_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && !done) |=> !$stable(cnt));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CW = 4,
    parameter logic [CW-1:0] RD_LD = '0,
    parameter logic [CW-1:0] WP_LD = '0,
    parameter logic [CW-1:0] TA_LD = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic          done,
    output phase_e        phase,
    output logic          accept,
    output logic          capture,
    output logic          finish,
    output logic          load,
    output logic [CW-1:0] load_val
);
    phase_e nxt;

    always_comb begin
        nxt      = phase;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        load     = 1'b0;
        load_val = '0;
        case (phase)
            PH_IDLE: if (req) begin
                accept = 1'b1;
                if (req_we) begin
                    nxt = PH_WSET;
                end else begin
                    nxt      = PH_READ;
                    load     = 1'b1;
                    load_val = RD_LD;
                end
            end
            PH_READ: if (done) begin
                capture  = 1'b1;
                finish   = 1'b1;
                nxt      = PH_TURN;
                load     = 1'b1;
                load_val = TA_LD;
            end
            PH_TURN: if (done) nxt = PH_IDLE;
            PH_WSET: begin
                nxt      = PH_WSTB;
                load     = 1'b1;
                load_val = WP_LD;
            end
            PH_WSTB: if (done) begin
                finish = 1'b1;
                nxt    = PH_IDLE;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    // R7: a request is taken only from the idle phase
    assert_accept_idle_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> (phase == PH_READ || phase == PH_WSET));
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW     = 17,
    parameter int unsigned DW     = 8,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned T_RC   = 15,
    parameter int unsigned T_AA   = 15,
    parameter int unsigned T_ACE  = 15,
    parameter int unsigned T_OE   = 7,
    parameter int unsigned T_OHZ  = 7,
    parameter int unsigned T_CHZ  = 7,
    parameter int unsigned T_WP   = 10,
    parameter int unsigned T_AW   = 12,
    parameter int unsigned T_CW   = 12,
    parameter int unsigned T_DW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] dq_out,
    input  logic [DW-1:0] dq_in,
    output logic          dq_oe,
    output logic          ce_n,
    output logic          ce2,
    output logic          we_n,
    output logic          oe_n
);
    localparam int unsigned RD_CYC = cycles_for(max2(max2(T_RC, T_AA), max2(T_ACE, T_OE)), CLK_NS);
    localparam int unsigned WP_CYC = cycles_for(max2(max2(T_WP, T_AW), max2(T_CW, T_DW)), CLK_NS);
    localparam int unsigned TA_CYC = cycles_for(max2(T_OHZ, T_CHZ), CLK_NS);
    localparam int unsigned CW     = width_for(max2(max2(RD_CYC, WP_CYC), TA_CYC));
    localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

    phase_e        phase;
    logic          accept, capture, finish, load, done;
    logic [CW-1:0] load_val;
    pins_t         pins;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .done(done)
    );

    sram_seq_fsm #(.CW(CW), .RD_LD(RD_LD), .WP_LD(WP_LD), .TA_LD(TA_LD)) u_fsm (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .done(done),
        .phase(phase), .accept(accept), .capture(capture), .finish(finish),
        .load(load), .load_val(load_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr <= '0;
            dq_out    <= '0;
            rdata     <= '0;
            ack       <= 1'b0;
        end else begin
            ack <= finish;
            if (accept) begin
                sram_addr <= req_addr;
                dq_out    <= req_wdata;
            end
            if (capture) rdata <= dq_in;
        end
    end

    assign pins  = pins_for(phase);
    assign ce_n  = pins.ce_n;
    assign ce2   = pins.ce2;
    assign we_n  = pins.we_n;
    assign oe_n  = pins.oe_n;
    assign dq_oe = pins.drive;

    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    assert_ack_after_select_R6: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(!ce_n));
    assert_drive_after_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(!ce_n && we_n && oe_n));
    assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe);
    assert_release_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |=> (ce_n && !dq_oe));
    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(sram_addr));
endmodule

// File: tb/sram_bus_ctrl_test.sv
`timescale 1ns/1ps
module sram_bus_ctrl_test;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req = 1'b0, req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack, dq_oe, ce_n, ce2, we_n, oe_n;
    logic [7:0]  rdata, dq_out, dq_in;
    logic [16:0] sram_addr;

    int errors = 0, checks = 0;
    int rd_n, wp_n, ta_n;
    int rcnt = 0, we_run = 0, oe_run = 0, gap = 0;
    bit after_read = 0;
    logic [7:0]  wlat;
    logic [16:0] wadr;
    logic [7:0] mem_model [int];
    logic [7:0] exp_mem [int];

    always #(CLK_NS/2) clk = ~clk;

    sram_bus_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .sram_addr(sram_addr),
        .dq_out(dq_out), .dq_in(dq_in), .dq_oe(dq_oe), .ce_n(ce_n), .ce2(ce2),
        .we_n(we_n), .oe_n(oe_n)
    );

    function automatic int cyc(int ns);
        int c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic [7:0] init_byte(int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16) ^ 8'h3C;
    endfunction

    function automatic logic [7:0] model_rd(int a);
        return mem_model.exists(a) ? mem_model[a] : init_byte(a);
    endfunction

    function automatic logic [7:0] exp_rd(int a);
        return exp_mem.exists(a) ? exp_mem[a] : init_byte(a);
    endfunction

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // memory model: data becomes valid only once the access time has elapsed
    wire rd_act = !ce_n && ce2 && we_n && !oe_n;
    always @(posedge clk) rcnt <= rd_act ? rcnt + 1 : 0;
    assign dq_in = !rd_act ? 8'h5A :
                   ((rcnt + 1 >= rd_n) ? model_rd(int'(sram_addr)) : ~model_rd(int'(sram_addr)));

    always @(negedge clk) if (!rst) begin
        if (dq_oe != !we_n) chk(0, "R4 driver vs strobe", dq_oe, !we_n);
        if (!we_n) begin
            we_run++;
            wlat = dq_oe ? dq_out : 8'hxx;
            wadr = sram_addr;
        end else if (we_run > 0) begin
            chk(we_run == wp_n, "R3 strobe length", we_run, wp_n);
            mem_model[int'(wadr)] = wlat;
            we_run = 0;
        end
        if (!oe_n) oe_run++;
        else if (oe_run > 0) begin
            chk(oe_run == rd_n, "R2 read length", oe_run, rd_n);
            oe_run = 0; after_read = 1; gap = 0;
        end
        if (after_read) begin
            if (ce_n && !dq_oe) gap++;
            else begin
                chk(gap >= ta_n, "R5 turnaround", gap, ta_n);
                after_read = 0;
            end
        end
    end

    task automatic do_op(input bit we, input logic [16:0] a, input logic [7:0] d, input bit hold_other);
        int n = 0;
        @(negedge clk);
        req = 1; req_we = we; req_addr = a; req_wdata = d;
        while (ce_n) @(negedge clk);
        chk(sram_addr == a, "R2 R3 address on bus", sram_addr, a);
        if (we) chk(we_n && oe_n, "R3 setup cycle", {we_n, oe_n}, 2'b11);
        if (hold_other) begin
            req_we = 1; req_addr = a ^ 17'h155; req_wdata = ~d;
        end else req = 0;
        while (!ack) begin @(negedge clk); n++; end
        req = 0;
        chk(n == (we ? 1 + wp_n : rd_n), "R6 ack latency", n, we ? 1 + wp_n : rd_n);
        if (we) exp_mem[int'(a)] = d;
        else chk(rdata == exp_rd(int'(a)), "R2 read data", rdata, exp_rd(int'(a)));
        @(negedge clk);
        chk(!ack, "R6 single pulse", ack, 0);
        if (we) chk(ce_n && !ce2 && we_n && oe_n && !dq_oe, "R1 standby when idle",
                    {ce_n, ce2, we_n, oe_n, dq_oe}, 5'b10110);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [16:0] ra;
        rd_n = cyc(15); wp_n = cyc(12); ta_n = cyc(7);
        // R8: limits under one period still give a phase of one cycle
        chk(cyc(3) == 1, "R8 minimum one cycle", cyc(3), 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ce_n && !ce2 && we_n && oe_n && !dq_oe, "R1 reset standby",
            {ce_n, ce2, we_n, oe_n, dq_oe}, 5'b10110);
        rst = 0;
        @(negedge clk);
        chk(ce_n && !ce2 && !ack, "R1 after reset", {ce_n, ce2}, 2'b10);

        do_op(1, 17'h00000, 8'hA5, 0);
        do_op(0, 17'h00000, 8'h00, 0);
        do_op(1, 17'h1FFFF, 8'h3C, 0);
        do_op(0, 17'h1FFFF, 8'h00, 0);
        do_op(0, 17'h12345, 8'h00, 0);
        do_op(0, 17'h00042, 8'h00, 0);      // read directly followed by a write (R5)
        do_op(1, 17'h00042, 8'hFF, 0);
        do_op(1, 17'h00100, 8'h11, 1);      // R7: request held during the transfer
        do_op(0, 17'h00100 ^ 17'h155, 8'h00, 0);
        do_op(0, 17'h00100, 8'h00, 0);

        void'($urandom(32'd7));
        for (int i = 0; i < 60; i++) begin
            ra = 17'h0A000 | 17'($urandom % 16);
            do_op(1'($urandom % 2), ra, 8'($urandom), 0);
        end
        for (int i = 0; i < 16; i++) do_op(0, 17'h0A000 | 17'(i), 8'h00, 0);
        finish_run();
    end
endmodule